// File: doc/BRIEF.md
# Burst-of-Four DDR SRAM Read Path

This block models the read side of a pipelined burst SRAM whose data output runs at double rate. A read command and an address are sampled on the command clock. Each accepted read becomes four data words of 18 bits. The first word comes from the given address. The next three come from the same aligned group of four, with the low two address bits stepping up and wrapping. For synthesis the double-rate output is modelled as one word per cycle of `clk_i`, which runs at twice the command rate. Every second rising edge of `clk_i` is a command edge.

A read takes two command cycles. Because of this, a read request on the command edge right after an accepted read is dropped without effect. Reads placed on every other command edge stream words with no gap. The latency input `lat_full_i` chooses between two read latencies: one and a half command cycles, or one command cycle. The output enable is high only while burst words are on the bus, so it also serves as the data-valid flag. A small internal array with a synchronous preload port supplies the read data.

Top module: `ddr_burst_rd`

## Requirements
- R1: A read is accepted only when `rd_sel_i`=1 and `ld_ni`=0 at a command edge. Any other combination of these two inputs produces no output words.
- R2: Command edges are every second rising edge of `clk_i`, starting with the first edge after reset is released. A read request held only across a non-command edge is ignored.
- R3: Each accepted read drives exactly four words on four consecutive `clk_i` cycles.
- R4: Word k (k=0..3) of a read at address A comes from address {A[ADDR_W-1:2], (A[1:0]+k) mod 4}. The upper bits stay fixed and the low two bits wrap.
- R5: With `lat_full_i`=1 the first word is on `dq_o` after the 3rd `clk_i` edge following the command edge (1.5 command cycles). With `lat_full_i`=0 it is there after the 2nd edge (1 command cycle).
- R6: A read request on the command edge right after an accepted read is ignored. A request on the command edge after that one is accepted.
- R7: Reads issued on every other command edge produce an unbroken run of words, four per read, in issue order.
- R8: `dq_oe_o` is high exactly while burst words are on `dq_o`. It falls at the first `clk_i` edge after the last word of the last pending burst.
- R9: When `pl_we_i`=1 at a `clk_i` edge, `pl_data_i` is written to `pl_addr_i`. Later reads return the newest written value.
- R10: While `rst_ni` is low, `dq_oe_o` is 0 at once. A burst that was pending when reset was asserted produces no words after reset is released.
- R11: The data word is DATA_W bits wide, with a default of 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock, twice the command rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lat_full_i | input | 1 | 1: latency of 1.5 command cycles, 0: latency of 1 command cycle |
| rd_sel_i | input | 1 | Read select, high for a read |
| ld_ni | input | 1 | Active-low load strobe |
| addr_i | input | ADDR_W | Read start address |
| pl_we_i | input | 1 | Preload write enable |
| pl_addr_i | input | ADDR_W | Preload address |
| pl_data_i | input | DATA_W | Preload data |
| dq_o | output | DATA_W | Read data word |
| dq_oe_o | output | 1 | Output enable, high while a word is valid |

## Verification
Counted in `clk_i` edges from the command edge c, word 0 of a burst is due just after edge c+3 with `lat_full_i` high and just after edge c+2 with it low. Words 1 to 3 follow on the next three edges, and the enable falls one edge after word 3. The bench keeps its own count of edges since reset, so it knows which edges are command edges. It drives commands at the falling edge before a command edge and samples on falling edges exactly L+1+k of them later. It also checks that the enable is still low one falling edge before word 0, and low again one falling edge after word 3. Sequences of commands run the driver and the sampler in parallel, so that dropped, streamed and overlapping reads are all checked slot by slot.

// File: rtl/ddr_burst_rd_pkg.sv
package ddr_burst_rd_pkg;
  localparam int BEAT_W    = 2;
  localparam int BURST_LEN = 1 << BEAT_W;
  // delay taps from accept strobe to burst launch
  localparam int TAP_HALF  = 1;
  localparam int TAP_FULL  = 2;
  localparam int DLY_LEN   = TAP_FULL + 1;
endpackage

// File: rtl/ddr_burst_rd_cmd.sv
module ddr_burst_rd_cmd
  import ddr_burst_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_full_i,
  input  logic              rd_sel_i,
  input  logic              ld_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_o,
  output logic              launch_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic               phase_q;
  logic               prev_q;
  logic [DLY_LEN-1:0] dly_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               cmd_edge;
  logic               acc_now;

  assign cmd_edge = ~phase_q;
  // drop a request that follows an accepted read
  assign acc_now  = cmd_edge & rd_sel_i & ~ld_ni & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      prev_q   <= 1'b0;
      dly_q[0] <= 1'b0;
      addr_q   <= '0;
    end else begin
      phase_q  <= ~phase_q;
      dly_q[0] <= acc_now;
      if (cmd_edge) prev_q <= acc_now;
      if (acc_now)  addr_q <= addr_i;
    end
  end

  for (genvar i = 1; i < DLY_LEN; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[i] <= 1'b0;
      else         dly_q[i] <= dly_q[i-1];
    end
  end

  assign acc_o    = dly_q[0];
  assign launch_o = lat_full_i ? dly_q[TAP_FULL] : dly_q[TAP_HALF];
  assign addr_o   = addr_q;
endmodule

// File: rtl/ddr_burst_rd_array.sv
module ddr_burst_rd_array #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ddr_burst_rd_seq.sv
module ddr_burst_rd_seq
  import ddr_burst_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_nxt;
  logic              more_q;
  logic              oe_q;
  logic [DATA_W-1:0] dq_q;

  // wrap inside the aligned group
  assign low_nxt = base_q[BEAT_W-1:0] + beat_q;
  assign raddr_o = launch_i ? start_addr_i : {base_q[ADDR_W-1:BEAT_W], low_nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
      more_q <= 1'b0;
      oe_q   <= 1'b0;
      dq_q   <= '0;
    end else if (launch_i) begin
      base_q <= start_addr_i;
      beat_q <= BEAT_W'(1);
      more_q <= 1'b1;
      oe_q   <= 1'b1;
      dq_q   <= rdata_i;
    end else if (more_q) begin
      beat_q <= beat_q + BEAT_W'(1);
      if (beat_q == BEAT_W'(BURST_LEN - 1)) more_q <= 1'b0;
      dq_q   <= rdata_i;
    end else begin
      oe_q   <= 1'b0;
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;
endmodule

// File: rtl/ddr_burst_rd.sv
module ddr_burst_rd #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_full_i,
  input  logic              rd_sel_i,
  input  logic              ld_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pl_we_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [DATA_W-1:0] pl_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              acc_w;
  logic              launch_w;
  logic [ADDR_W-1:0] start_w;
  logic [ADDR_W-1:0] raddr_w;
  logic [DATA_W-1:0] rdata_w;

  ddr_burst_rd_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk_i, .rst_ni, .lat_full_i, .rd_sel_i, .ld_ni, .addr_i,
    .acc_o(acc_w), .launch_o(launch_w), .addr_o(start_w)
  );

  ddr_burst_rd_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk_i, .we_i(pl_we_i), .waddr_i(pl_addr_i), .wdata_i(pl_data_i),
    .raddr_i(raddr_w), .rdata_o(rdata_w)
  );

  ddr_burst_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .launch_i(launch_w), .start_addr_i(start_w),
    .raddr_o(raddr_w), .rdata_i(rdata_w), .dq_o, .dq_oe_o
  );
endmodule

// File: rtl/ddr_burst_rd_chk.sv
module ddr_burst_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lat_full_i,
  input logic rd_sel_i,
  input logic ld_ni,
  input logic acc_i,
  input logic dq_oe_o
);
  a_r1_accept_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> $past(rd_sel_i && !ld_ni));

  a_r6_no_consecutive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> !$past(acc_i, 2));

  a_r5_full_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && lat_full_i) |=> ##2 dq_oe_o);

  a_r5_half_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !lat_full_i) |=> ##1 dq_oe_o);

  a_r3_four_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |=> dq_oe_o ##1 dq_oe_o ##1 dq_oe_o);

  a_r8_drop_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> $past(dq_oe_o, 4));
endmodule

bind ddr_burst_rd ddr_burst_rd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lat_full_i(lat_full_i), .rd_sel_i(rd_sel_i),
  .ld_ni(ld_ni), .acc_i(acc_w), .dq_oe_o(dq_oe_o)
);

// File: tb/ddr_burst_rd_bench.sv
`timescale 1ns/1ps
module ddr_burst_rd_bench;
  localparam int DATA_W = 18;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lat_full = 1'b1;
  logic              rd_sel = 1'b0;
  logic              ld_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              pl_we = 1'b0;
  logic [ADDR_W-1:0] pl_addr = '0;
  logic [DATA_W-1:0] pl_data = '0;
  logic [DATA_W-1:0] dq;
  logic              dq_oe;

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;
  bit done = 0;
  logic [DATA_W-1:0] shadow [DEPTH];

  always #2 clk = ~clk;

  ddr_burst_rd u_ddr_burst_rd (
    .clk_i(clk), .rst_ni(rst_n), .lat_full_i(lat_full), .rd_sel_i(rd_sel),
    .ld_ni(ld_n), .addr_i(addr), .pl_we_i(pl_we), .pl_addr_i(pl_addr),
    .pl_data_i(pl_data), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int slot_addr(input int a, input int k);
    return (a & ~3 & (DEPTH - 1)) | ((a + k) & 3);
  endfunction

  task automatic wait_cmd_edge();
    do @(negedge clk); while (edges % 2 != 0);
  endtask

  task automatic preload(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = ADDR_W'(a); pl_data = d;
    shadow[a] = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  // nc commands on consecutive command edges; ne bursts expected back to back
  task automatic run_cmds(input int nc, input bit cr[6], input bit cl[6], input int ca[6],
                          input int ne, input int ea[3], input bit full, input string req);
    int lat = full ? 3 : 2;
    lat_full = full;
    wait_cmd_edge();
    rd_sel = cr[0]; ld_n = cl[0]; addr = ADDR_W'(ca[0]);
    fork
      begin
        for (int i = 1; i < nc; i++) begin
          wait_cmd_edge();
          rd_sel = cr[i]; ld_n = cl[i]; addr = ADDR_W'(ca[i]);
        end
        @(negedge clk);
        rd_sel = 1'b0; ld_n = 1'b1;
      end
      begin
        repeat (lat) @(negedge clk);
        check(dq_oe == 1'b0, {req, " R5 no early word"}, 32'(dq_oe), 0);
        if (ne == 0) begin
          for (int s = 0; s < 2 * nc + 6; s++) begin
            @(negedge clk);
            check(dq_oe == 1'b0, {req, " R1 no output"}, 32'(dq_oe), 0);
          end
        end else begin
          for (int b = 0; b < ne; b++)
            for (int k = 0; k < 4; k++) begin
              @(negedge clk);
              check(dq_oe == 1'b1, {req, " R3/R7/R8 word valid"}, 32'(dq_oe), 1);
              check(dq == shadow[slot_addr(ea[b], k)], {req, " R4 word data"},
                    32'(dq), 32'(shadow[slot_addr(ea[b], k)]));
            end
          @(negedge clk);
          check(dq_oe == 1'b0, {req, " R8 enable drops"}, 32'(dq_oe), 0);
        end
      end
    join
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(dq_oe == 1'b0, "R10 reset state", 32'(dq_oe), 0);
  endtask

  task automatic t_single_full();
    run_cmds(1, '{1,0,0,0,0,0}, '{0,1,1,1,1,1}, '{8'h40,0,0,0,0,0},
             1, '{8'h40,0,0}, 1'b1, "R5 full latency");
  endtask

  task automatic t_single_half_wrap();
    run_cmds(1, '{1,0,0,0,0,0}, '{0,1,1,1,1,1}, '{8'h57,0,0,0,0,0},
             1, '{8'h57,0,0}, 1'b0, "R4/R5 half latency wrap");
  endtask

  task automatic t_wrap_full();
    run_cmds(1, '{1,0,0,0,0,0}, '{0,1,1,1,1,1}, '{8'hFE,0,0,0,0,0},
             1, '{8'hFE,0,0}, 1'b1, "R4 wrap at top");
  endtask

  task automatic t_no_accept();
    run_cmds(3, '{0,1,0,0,0,0}, '{0,1,1,1,1,1}, '{8'h10,8'h11,8'h12,0,0,0},
             0, '{0,0,0}, 1'b1, "R1 bad strobe combos");
  endtask

  task automatic t_collision();
    run_cmds(3, '{1,1,1,0,0,0}, '{0,0,0,1,1,1}, '{8'h20,8'h31,8'h46,0,0,0},
             2, '{8'h20,8'h46,0}, 1'b1, "R6 collision drop");
  endtask

  task automatic t_stream_half();
    run_cmds(5, '{1,0,1,0,1,0}, '{0,1,0,1,0,1}, '{8'h03,0,8'h81,0,8'hC2,0},
             3, '{8'h03,8'h81,8'hC2}, 1'b0, "R7 stream");
  endtask

  task automatic t_odd_edge();
    wait_cmd_edge();
    @(negedge clk);
    rd_sel = 1'b1; ld_n = 1'b0; addr = 8'h66;
    @(negedge clk);
    rd_sel = 1'b0; ld_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      check(dq_oe == 1'b0, "R2 non-command edge ignored", 32'(dq_oe), 0);
    end
  endtask

  task automatic t_preload_update();
    preload(8'h91, 18'h2BEEF);
    run_cmds(1, '{1,0,0,0,0,0}, '{0,1,1,1,1,1}, '{8'h90,0,0,0,0,0},
             1, '{8'h90,0,0}, 1'b1, "R9 preload update");
  endtask

  task automatic t_reset_mid();
    lat_full = 1'b1;
    wait_cmd_edge();
    rd_sel = 1'b1; ld_n = 1'b0; addr = 8'h70;
    @(negedge clk);
    rd_sel = 1'b0; ld_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dq_oe == 1'b1, "R10 burst running before reset", 32'(dq_oe), 1);
    rst_n = 1'b0;
    #1;
    check(dq_oe == 1'b0, "R10 enable cleared by reset", 32'(dq_oe), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      check(dq_oe == 1'b0, "R10 pending burst discarded", 32'(dq_oe), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++)
      preload(a, DATA_W'((a * 1031 + 18'h1234) ^ (a << 9)));
    check($bits(dq) == 18, "R11 word width", 32'($bits(dq)), 18);
    t_single_full();
    t_single_half_wrap();
    t_wrap_full();
    t_no_accept();
    t_collision();
    t_stream_half();
    t_odd_edge();
    t_preload_update();
    t_reset_mid();
    t_single_half_wrap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule